// File: doc/BRIEF.md
# Serial Digital Video Encoder

This block turns a stream of 10-bit parallel video words into a serial bitstream carrying ten bits per word. A serial-clock enable marks each serial slot, and every group of ten slots forms one frame. On the first slot of a frame the block samples the parallel word. A frame-start marker tells downstream logic where word boundaries fall. A strobe input can force a new frame to begin on any slot, which re-aligns the framing to an external word clock.

Before a word is serialized, it can be conditioned for 8-bit sources. Unless folding is disabled, the four lowest codes collapse to all-zeros and the four highest codes collapse to all-ones. This keeps the timing-reference codes intact when the two least significant bits are missing. The serialized bits then pass through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1, and the scrambled stream is turned into NRZI. A single bypass input removes both the scrambling and the NRZI stage, so the raw word bits appear on the output. A separate synchronous input clears the scrambler history.

Top module: `sdi_serializer`

## Requirements
- R1: After the asynchronous reset, `ser_out` and `frame_start` are 0, the scrambler history is all-zeros and the NRZI level is 0.
- R2: Each frame emits ten bits, least significant first. Bit i of the frame is bit i of the word sampled on the frame's first slot. Changes on `word_in` during slots 1 to 9 have no effect.
- R3: `frame_start` is high for exactly one clock, namely the clock after the enable that emits slot 0. In that same clock `ser_out` shows bit 0 of the word.
- R4: With `sync_dis` low, input words 0x000 to 0x003 are serialized as 0x000.
- R5: With `sync_dis` low, input words 0x3FC to 0x3FF are serialized as 0x3FF.
- R6: With `sync_dis` high, every word is serialized unchanged. In either mode, 0x004 and 0x3FB are never altered.
- R7: With `byp` low, each scrambled bit is s(n) = d(n) ^ s(n-4) ^ s(n-9). The output level toggles when s(n) is 1 and holds when s(n) is 0.
- R8: With `byp` high, `ser_out` carries the raw bit d(n). The scrambler history and the NRZI level stay unchanged.
- R9: `scr_clr` high on a clock edge sets the scrambler history to all-zeros. The NRZI level is not affected.
- R10: `word_stb` high together with `ser_en` makes that slot slot 0 of a new frame, whatever the current slot is.
- R11: While `ser_en` is low, `ser_out` holds, the slot position does not advance and `frame_start` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_en | input | 1 | Serial slot enable, one per serial bit |
| word_in | input | 10 | Parallel video word, bit 0 least significant |
| word_stb | input | 1 | Forces the current slot to be slot 0 of a frame |
| byp | input | 1 | High: skip the scrambler and the NRZI stage |
| sync_dis | input | 1 | High: disable folding of the low and high code ranges |
| scr_clr | input | 1 | Synchronous clear of the scrambler history |
| ser_out | output | 1 | Serial output bit |
| frame_start | output | 1 | One-clock pulse that marks bit 0 of a frame |

## Verification
The assertions assume that `word_in`, `sync_dis` and `byp` are valid on every slot-0 enable. They also assume that `byp` changes only at frame boundaries, so a single frame is never partly scrambled. The bench changes every input on the falling clock edge. It switches `byp` and `sync_dis` only between whole words, and it toggles `word_in` mid-frame only to show that those changes are ignored. It drives `scr_clr` only while `ser_en` is low, so a clear never coincides with an emitted bit.

// File: rtl/sdi_serializer.sv
module sdi_serializer #(
  parameter int SCR_TAP_A = 4,
  parameter int SCR_TAP_B = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_en,
  input  logic [9:0] word_in,
  input  logic       word_stb,
  input  logic       byp,
  input  logic       sync_dis,
  input  logic       scr_clr,
  output logic       ser_out,
  output logic       frame_start
);
  localparam int         W    = 10;
  localparam int         SW   = $clog2(W);
  localparam logic [SW-1:0] LAST = SW'(W - 1);

  logic [SW-1:0]        slot;
  logic [W-1:0]         sh;
  logic [SCR_TAP_B-1:0] scr;
  logic                 lvl;
  logic [W-1:0]         folded;

  wire first   = word_stb || (slot == LAST);
  wire lo_code = (word_in[W-1:2] == '0);
  wire hi_code = (&word_in[W-1:2]);

  always_comb begin
    folded = word_in;
    if (!sync_dis && lo_code) folded = '0;
    else if (!sync_dis && hi_code) folded = '1;
  end

  wire nrz     = first ? folded[0] : sh[0];
  wire scr_bit = nrz ^ scr[SCR_TAP_A-1] ^ scr[SCR_TAP_B-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot        <= LAST;
      sh          <= '0;
      scr         <= '0;
      lvl         <= 1'b0;
      ser_out     <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= ser_en && first;
      if (ser_en) begin
        slot <= first ? '0 : slot + 1'b1;
        sh   <= first ? {1'b0, folded[W-1:1]} : {1'b0, sh[W-1:1]};
        if (byp) begin
          ser_out <= nrz;
        end else begin
          ser_out <= lvl ^ scr_bit;
          lvl     <= lvl ^ scr_bit;
        end
      end
      if (scr_clr) scr <= '0;
      else if (ser_en && !byp) scr <= {scr[SCR_TAP_B-2:0], scr_bit};
    end
  end

  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);

  p_frame_after_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(ser_en));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> ($stable(ser_out) && !frame_start));

  p_fold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && first && byp && !sync_dis && lo_code) |=> !ser_out);

  p_fold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && first && byp && !sync_dis && hi_code) |=> ser_out);

  p_bypass_keeps_scr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byp && !scr_clr) |=> $stable(scr));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scr_clr |=> (scr == '0));
endmodule

// File: tb/tb_sdi_serializer.sv
`timescale 1ns/1ps
module tb_sdi_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_en = 1'b0;
  logic [9:0] word_in = '0;
  logic       word_stb = 1'b0;
  logic       byp = 1'b1;
  logic       sync_dis = 1'b1;
  logic       scr_clr = 1'b0;
  logic       ser_out;
  logic       frame_start;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [8:0] m_scr = '0;
  logic       m_lvl = 1'b0;

  always #4 clk = ~clk;

  sdi_serializer dut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .word_in(word_in),
    .word_stb(word_stb), .byp(byp), .sync_dis(sync_dis), .scr_clr(scr_clr),
    .ser_out(ser_out), .frame_start(frame_start)
  );

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] fold_ref(input logic [9:0] w, input logic sd);
    if (!sd && w <= 10'h003) return 10'h000;
    if (!sd && w >= 10'h3FC) return 10'h3FF;
    return w;
  endfunction

  function automatic logic model_bit(input logic d);
    logic s;
    if (byp) return d;
    s     = d ^ m_scr[3] ^ m_scr[8];
    m_scr = {m_scr[7:0], s};
    m_lvl = m_lvl ^ s;
    return m_lvl;
  endfunction

  task automatic run_word(input logic [9:0] w, input string req);
    logic [9:0] fw, got, expv, fs;
    fw = fold_ref(w, sync_dis);
    for (int i = 0; i < 10; i++) begin
      word_in  = (i == 0) ? w : ~w;
      word_stb = (i == 0);
      @(posedge clk); @(negedge clk);
      got[i]  = ser_out;
      expv[i] = model_bit(fw[i]);
      fs[i]   = frame_start;
    end
    word_stb = 1'b0;
    check(got == expv, req, got, expv);
    check(fs == 10'h001, {req, " R3 frame_start"}, fs, 10'h001);
  endtask

  task automatic t_reset;
    check(ser_out == 1'b0 && frame_start == 1'b0, "R1 reset outputs",
          {8'd0, ser_out, frame_start}, 10'd0);
  endtask

  task automatic t_lsb_first;
    byp = 1'b1; sync_dis = 1'b1;
    run_word(10'h2A5, "R2 lsb first");
    run_word(10'h1C3, "R2 second word");
  endtask

  task automatic t_fold;
    byp = 1'b1; sync_dis = 1'b0;
    run_word(10'h002, "R4 fold 002");
    run_word(10'h003, "R4 fold 003");
    run_word(10'h3FC, "R5 fold 3FC");
    run_word(10'h3FD, "R5 fold 3FD");
    run_word(10'h004, "R6 edge 004");
    run_word(10'h3FB, "R6 edge 3FB");
    sync_dis = 1'b1;
    run_word(10'h002, "R6 pass 002");
    run_word(10'h3FD, "R6 pass 3FD");
  endtask

  task automatic t_scramble;
    byp = 1'b0; sync_dis = 1'b1;
    run_word(10'h3FF, "R7 scramble 3FF");
    run_word(10'h000, "R7 scramble 000");
    run_word(10'h000, "R7 scramble 000b");
    run_word(10'h2D9, "R7 scramble 2D9");
    byp = 1'b1;
    run_word(10'h155, "R8 bypass raw");
    byp = 1'b0;
    run_word(10'h0F0, "R8 state kept across bypass");
  endtask

  task automatic t_clear;
    byp = 1'b0; sync_dis = 1'b1;
    ser_en = 1'b0; scr_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    scr_clr = 1'b0; ser_en = 1'b1;
    m_scr = '0;
    run_word(10'h000, "R9 after clear");
    run_word(10'h31B, "R9 after clear b");
  endtask

  task automatic t_realign;
    byp = 1'b1; sync_dis = 1'b1;
    word_in = 10'h0AA; word_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    word_stb = 1'b0;
    for (int k = 1; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
    end
    run_word(10'h36C, "R10 realign");
  endtask

  task automatic t_gaps;
    logic [9:0] w, hold_ok, bits, fs_on, fs_off;
    byp = 1'b1; sync_dis = 1'b1; w = 10'h1B6;
    for (int i = 0; i < 10; i++) begin
      word_in = (i == 0) ? w : ~w;
      word_stb = (i == 0);
      ser_en = 1'b1;
      @(posedge clk); @(negedge clk);
      word_stb = 1'b0; ser_en = 1'b0;
      bits[i]  = ser_out;
      fs_on[i] = frame_start;
      @(posedge clk); @(negedge clk);
      hold_ok[i] = (ser_out == bits[i]);
      fs_off[i]  = frame_start;
    end
    ser_en = 1'b1;
    check(bits == w, "R11 bits with gaps", bits, w);
    check(hold_ok == 10'h3FF, "R11 hold while disabled", hold_ok, 10'h3FF);
    check(fs_off == 10'h000, "R11 no marker while disabled", fs_off, 10'h000);
    check(fs_on == 10'h001, "R3 marker with gaps", fs_on, 10'h001);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    ser_en = 1'b1;
    t_lsb_first();
    t_fold();
    t_scramble();
    t_clear();
    t_realign();
    t_gaps();
    finish_run();
  end
endmodule